// File: doc/BRIEF.md
# Sized Integer ALU with Condition Flags

This block is the integer execution stage of a 32-bit register-based processor. Each accepted operation takes a source value, a destination value, an operand size (byte, word or longword), an opcode and a marker that says whether the destination is an address register. One clock later it presents the value to be written back, a write-enable for that value and a five-bit condition-flag register (extend X, negative N, zero Z, overflow V, carry C).

On data-register destinations every operation works at the selected size. Only the low 8 or 16 bits of the destination are replaced for byte or word work, and the flags describe the result at that size. Compare and test set the flags and never write. Address-register destinations follow a separate path. A word source is sign-extended to 32 bits before an add, subtract, move or compare. A write to an address register never disturbs the flags. Operations that make no sense for an address register are refused and have no effect.

The flag register holds its value between operations. X therefore keeps the last carry across logic operations. Instruction decode, address generation and memory access are done elsewhere.

Top module: `int_alu_flags`

## Requirements
- R1: After reset, `out_valid`, `wr_en`, `result` and `flags` are all zero.
- R2: An operation accepted with `in_valid` high at a clock edge shows on `out_valid`, `wr_en`, `result` and `flags` after that edge. Without `in_valid`, `out_valid` and `wr_en` are low and `result` and `flags` hold. `result` changes only when a write occurs. `flags` bits are X=4, N=3, Z=2, V=1, C=0.
- R3: Opcode 0 (add) and opcode 1 (subtract, destination minus source) on a data destination write the sum or difference at the size. Size codes are 0 byte, 1 word, 2 longword. N is the result's top bit at that size, and Z is set when the sized result is zero. V is signed overflow, C is carry or borrow, and X takes the value of C.
- R4: Opcode 6 (negate) writes zero minus the destination at the size. C and X are set when the sized operand is non-zero. V is set only for the most negative value. Opcode 5 (complement) writes the bitwise inversion.
- R5: Opcodes 2 (AND), 3 (OR), 4 (XOR), 5 (complement) and 12 (move source) on a data destination set N and Z from the sized result, clear V and C, and leave X unchanged.
- R6: For byte or word operations on a data destination, the destination bits above the size are written back unchanged.
- R7: Opcode 8 (compare) sets N, Z, V and C as a subtract of the source from the destination would. X is unchanged and no write occurs.
- R8: Opcode 9 (test) sets N and Z from the sized destination and clears V and C. X is unchanged and no write occurs.
- R9: Opcode 10 (sign-extend) with size 1 extends the low byte to 16 bits and keeps bits 31:16. With size 2 it extends the low word to 32 bits. N and Z come from the widened result, and V and C are cleared.
- R10: Opcode 11 (swap) exchanges bits 31:16 and 15:0 of the destination. N and Z come from the 32-bit result, and V and C are cleared.
- R11: Opcode 7 (clear) on a data destination writes zeros at the size and sets Z. N, V and C are cleared and X is unchanged.
- R12: With `dst_is_addr` high, add, subtract and move write a full 32-bit result using a source sign-extended from 16 bits when the size is not longword, and leave all flags unchanged. Compare sets N, Z, V and C from the 32-bit difference against the extended source, without a write.
- R13: With `dst_is_addr` high, every other opcode, clear included, writes nothing and leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Opcode (see requirements) |
| size | input | 2 | Operand size: 0 byte, 1 word, 2 longword |
| dst_is_addr | input | 1 | Destination is an address register |
| src | input | 32 | Source operand |
| dst | input | 32 | Current destination value |
| out_valid | output | 1 | Result of the previous cycle's operation is present |
| result | output | 32 | Value to write to the destination |
| wr_en | output | 1 | Destination is to be written with `result` |
| flags | output | 5 | Condition flags {X, N, Z, V, C} |

## Verification
The properties assume that `op` stays within codes 0 to 12 and that `size` is never 3. They also assume that address-register destinations are only given word or longword sizes. Codes outside these ranges have defined but unspecified outcomes that the properties do not cover. Both the directed vectors and the random phase of the stimulus draw only from these legal ranges, and any random byte size paired with an address destination is raised to word. Corner values are included: the most negative number at each size, zero and all-ones operands, and carries out of the top bit.

// File: rtl/alu_pkg.sv
// Package: shared widths, opcode and size codes, flag bit positions for the
// sized integer ALU. Assumes a 32-bit datapath with 8/16/32-bit operand sizes.
package alu_pkg;
    localparam int DATA_W  = 32;
    localparam int HALF_W  = DATA_W / 2;
    localparam int NUM_SZ  = 3;
    localparam int FLAG_W  = 5;
    localparam int FLG_X   = 4;
    localparam int FLG_N   = 3;
    localparam int FLG_Z   = 2;
    localparam int FLG_V   = 1;
    localparam int FLG_C   = 0;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_NOT  = 4'd5,
        OP_NEG  = 4'd6,
        OP_CLR  = 4'd7,
        OP_CMP  = 4'd8,
        OP_TST  = 4'd9,
        OP_EXT  = 4'd10,
        OP_SWAP = 4'd11,
        OP_MOVE = 4'd12
    } alu_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } alu_size_e;
endpackage

// File: rtl/alu_addsub.sv
// Sized adder/subtractor. Produces a zero-extended result, carry/borrow and
// signed overflow for byte, word and longword widths in parallel, then picks
// one by size. Assumes size code 3 is treated as longword.
module alu_addsub
    import alu_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    input  logic [1:0]        size,
    output logic [DATA_W-1:0] res,
    output logic              carry,
    output logic              ovf
);
    logic [DATA_W-1:0] res_w [NUM_SZ];
    logic              c_w   [NUM_SZ];
    logic              v_w   [NUM_SZ];

    for (genvar i = 0; i < NUM_SZ; i++) begin : g_width
        localparam int W = 8 << i;
        logic [W:0] s;
        // Per-width sum or difference with its carry bit.
        always_comb begin
            if (sub) s = {1'b0, a[W-1:0]} - {1'b0, b[W-1:0]};
            else     s = {1'b0, a[W-1:0]} + {1'b0, b[W-1:0]};
            res_w[i] = DATA_W'(s[W-1:0]);
            c_w[i]   = s[W];
            v_w[i]   = sub ? ((a[W-1] != b[W-1]) && (s[W-1] != a[W-1]))
                           : ((a[W-1] == b[W-1]) && (s[W-1] != a[W-1]));
        end
    end

    // Select the outputs for the requested size.
    always_comb begin
        case (size)
            SZ_BYTE: begin res = res_w[0]; carry = c_w[0]; ovf = v_w[0]; end
            SZ_WORD: begin res = res_w[1]; carry = c_w[1]; ovf = v_w[1]; end
            default: begin res = res_w[2]; carry = c_w[2]; ovf = v_w[2]; end
        endcase
    end
endmodule

// File: rtl/alu_bitops.sv
// Non-arithmetic result generator: bitwise logic, clear, move, test pass-through,
// sign-extension and half swap. Output is unmasked; the caller merges by size.
module alu_bitops
    import alu_pkg::*;
(
    input  logic [3:0]        op,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] dst,
    output logic [DATA_W-1:0] res
);
    // Compute the raw 32-bit result for the selected operation.
    always_comb begin
        case (op)
            OP_AND:  res = dst & src;
            OP_OR:   res = dst | src;
            OP_XOR:  res = dst ^ src;
            OP_NOT:  res = ~dst;
            OP_MOVE: res = src;
            OP_TST:  res = dst;
            OP_SWAP: res = {dst[HALF_W-1:0], dst[DATA_W-1:HALF_W]};
            OP_EXT:  res = (size == SZ_BYTE || size == SZ_WORD)
                           ? {dst[DATA_W-1:HALF_W], {8{dst[7]}}, dst[7:0]}
                           : {{HALF_W{dst[HALF_W-1]}}, dst[HALF_W-1:0]};
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/int_alu_flags.sv
// Sized integer ALU with a held condition-flag register. One operation per
// in_valid cycle, outputs registered one cycle later. Assumes op in 0..12 and
// size in 0..2; synchronous active-low reset.
module int_alu_flags
    import alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op,
    input  logic [1:0]        size,
    input  logic              dst_is_addr,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] dst,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic [FLAG_W-1:0] flags
);
    logic [DATA_W-1:0] src_ext, ar_a, ar_b, ar_res, lg_res, raw, mask, merged;
    logic [DATA_W-1:0] wdata;
    logic [1:0]        ar_size, fl_size;
    logic              ar_sub, ar_c, ar_v, is_arith, n_sz, z_sz, do_wr;
    logic [FLAG_W-1:0] flg_nx;

    // Address-target source: sign-extend a word to 32 bits.
    always_comb src_ext = (size == SZ_LONG) ? src
                        : {{HALF_W{src[HALF_W-1]}}, src[HALF_W-1:0]};

    // Arithmetic operand selection (negate is zero minus destination).
    always_comb begin
        ar_a    = (op == OP_NEG) ? '0 : dst;
        ar_b    = (op == OP_NEG) ? dst : (dst_is_addr ? src_ext : src);
        ar_sub  = (op != OP_ADD);
        ar_size = dst_is_addr ? SZ_LONG : size;
    end

    alu_addsub i_addsub (
        .a(ar_a), .b(ar_b), .sub(ar_sub), .size(ar_size),
        .res(ar_res), .carry(ar_c), .ovf(ar_v)
    );

    alu_bitops i_bitops (
        .op(op), .size(size), .src(src), .dst(dst), .res(lg_res)
    );

    // Size that governs the N/Z flags and the merge mask.
    always_comb begin
        if (dst_is_addr || op == OP_SWAP)  fl_size = SZ_LONG;
        else if (op == OP_EXT)             fl_size = (size == SZ_LONG) ? SZ_LONG : SZ_WORD;
        else                               fl_size = size;
    end

    // Raw result, size mask, N/Z and merged write value.
    always_comb begin
        is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_NEG) || (op == OP_CMP);
        raw      = is_arith ? ar_res : lg_res;
        case (fl_size)
            SZ_BYTE: begin mask = DATA_W'(8'hFF);    n_sz = raw[7]; end
            SZ_WORD: begin mask = DATA_W'(16'hFFFF); n_sz = raw[HALF_W-1]; end
            default: begin mask = '1;                n_sz = raw[DATA_W-1]; end
        endcase
        z_sz   = ((raw & mask) == '0);
        merged = (dst & ~mask) | (raw & mask);
    end

    // Write decision and next flag value.
    always_comb begin
        do_wr  = 1'b0;
        wdata  = merged;
        flg_nx = flags;
        if (dst_is_addr) begin
            case (op)
                OP_ADD, OP_SUB: begin do_wr = 1'b1; wdata = ar_res; end
                OP_MOVE:        begin do_wr = 1'b1; wdata = src_ext; end
                OP_CMP:         flg_nx = {flags[FLG_X], ar_res[DATA_W-1],
                                          (ar_res == '0), ar_v, ar_c};
                default:        ;
            endcase
        end else begin
            case (op)
                OP_ADD, OP_SUB, OP_NEG: begin
                    do_wr  = 1'b1;
                    flg_nx = {ar_c, n_sz, z_sz, ar_v, ar_c};
                end
                OP_CMP: flg_nx = {flags[FLG_X], n_sz, z_sz, ar_v, ar_c};
                OP_TST: flg_nx = {flags[FLG_X], n_sz, z_sz, 2'b00};
                OP_AND, OP_OR, OP_XOR, OP_NOT, OP_MOVE,
                OP_CLR, OP_EXT, OP_SWAP: begin
                    do_wr  = 1'b1;
                    flg_nx = {flags[FLG_X], n_sz, z_sz, 2'b00};
                end
                default: ;
            endcase
        end
    end

    // Output and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
            result    <= '0;
            flags     <= '0;
        end else begin
            out_valid <= in_valid;
            wr_en     <= in_valid && do_wr;
            if (in_valid && do_wr) result <= wdata;
            if (in_valid)          flags  <= flg_nx;
        end
    end
endmodule

// File: rtl/int_alu_flags_chk.sv
// Property checker for int_alu_flags, bound to every instance. Assumes legal
// op/size codes at the inputs.
module int_alu_flags_chk
    import alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op,
    input  logic [1:0]        size,
    input  logic              dst_is_addr,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] dst,
    input  logic              out_valid,
    input  logic [DATA_W-1:0] result,
    input  logic              wr_en,
    input  logic [FLAG_W-1:0] flags
);
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !wr_en && $stable(flags) && $stable(result)); // R2
    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op == OP_CMP |=> !wr_en && flags[FLG_X] == $past(flags[FLG_X])); // R7
    AST_TST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op == OP_TST && !dst_is_addr |=> !wr_en && !flags[FLG_V] && !flags[FLG_C]); // R8
    AST_LOGIC_KEEPS_X: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !dst_is_addr && (op == OP_AND || op == OP_OR || op == OP_XOR || op == OP_NOT)
        |=> flags[FLG_X] == $past(flags[FLG_X]) && !flags[FLG_V] && !flags[FLG_C]); // R5
    AST_BYTE_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !dst_is_addr && size == SZ_BYTE && op != OP_EXT && op != OP_SWAP
        && op != OP_CMP && op != OP_TST |=> result[DATA_W-1:8] == $past(dst[DATA_W-1:8])); // R6
    AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !dst_is_addr && op == OP_CLR
        |=> wr_en && flags[FLG_Z] && !flags[FLG_N] && !flags[FLG_V] && !flags[FLG_C]); // R11
    AST_ADDR_MOVE_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && dst_is_addr && op == OP_MOVE && size == SZ_WORD
        |=> wr_en && result == {{HALF_W{$past(src[HALF_W-1])}}, $past(src[HALF_W-1:0])}); // R12
    AST_ADDR_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && dst_is_addr && op != OP_CMP |=> $stable(flags)); // R13
endmodule

bind int_alu_flags int_alu_flags_chk i_chk (.*);

// File: tb/test_int_alu_flags.sv
// Testbench: behavioural reference model compared against the outputs every cycle.
module test_int_alu_flags;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [1:0]  size = '0;
    logic        dst_is_addr = 1'b0;
    logic [31:0] src = '0, dst = '0;
    logic        out_valid, wr_en;
    logic [31:0] result;
    logic [4:0]  flags;

    int errors = 0;
    int checks = 0;

    // model state
    logic [31:0] m_res = '0;
    logic [4:0]  m_flg = '0;
    logic        m_wr = 1'b0, m_vld = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    int_alu_flags i_int_alu_flags (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .size(size),
        .dst_is_addr(dst_is_addr), .src(src), .dst(dst), .out_valid(out_valid),
        .result(result), .wr_en(wr_en), .flags(flags)
    );

    function automatic string tag_of(int o, bit a);
        if (a) return (o == 0 || o == 1 || o == 12 || o == 8) ? "R12" : "R13";
        case (o)
            0, 1: return "R3";
            6:    return "R4";
            2, 3, 4, 5, 12: return "R5";
            7:    return "R11";
            8:    return "R7";
            9:    return "R8";
            10:   return "R9";
            11:   return "R10";
            default: return "R2";
        endcase
    endfunction

    // Reference model: updates m_res/m_flg/m_wr/m_vld for one accepted operation.
    task automatic model(int o, int sz, bit a, logic [31:0] s, logic [31:0] d);
        longint unsigned m, x, y, r;
        int w;
        bit fx, fn, fz, fv, fc, wr, setf;
        logic [31:0] sx;
        fx = m_flg[4]; fn = m_flg[3]; fz = m_flg[2]; fv = m_flg[1]; fc = m_flg[0];
        wr = 0; setf = 0;
        m_vld = 1;
        if (a) begin
            sx = (sz == 2) ? s : {{16{s[15]}}, s[15:0]};
            if (o == 0) begin m_res = d + sx; wr = 1; end
            else if (o == 1) begin m_res = d - sx; wr = 1; end
            else if (o == 12) begin m_res = sx; wr = 1; end
            else if (o == 8) begin
                x = longint'(d); y = longint'(sx);
                r = (x - y) & 64'hFFFF_FFFF;
                fn = r[31]; fz = (r == 0); fc = (x < y);
                fv = (x[31] != y[31]) && (r[31] != x[31]);
            end
            m_wr = wr;
            m_flg = {fx, fn, fz, fv, fc};
            return;
        end
        w = (o == 11) ? 32 : (o == 10) ? ((sz == 2) ? 32 : 16) : (8 << sz);
        m = (64'd1 << w) - 1;
        x = longint'(d) & m; y = longint'(s) & m;
        r = 0;
        case (o)
            0: begin r = (x + y) & m; fc = ((x + y) >> w) & 1;
                     fv = (x[w-1] == y[w-1]) && (r[w-1] != x[w-1]); fx = fc; wr = 1; end
            1, 8: begin r = (x - y) & m; fc = (x < y);
                     fv = (x[w-1] != y[w-1]) && (r[w-1] != x[w-1]);
                     if (o == 1) begin fx = fc; wr = 1; end end
            6: begin r = (0 - x) & m; fc = (x != 0); fv = x[w-1] && r[w-1];
                     fx = fc; wr = 1; end
            2: begin r = x & y;   fv = 0; fc = 0; wr = 1; end
            3: begin r = x | y;   fv = 0; fc = 0; wr = 1; end
            4: begin r = x ^ y;   fv = 0; fc = 0; wr = 1; end
            5: begin r = ~x & m;  fv = 0; fc = 0; wr = 1; end
            12: begin r = y;      fv = 0; fc = 0; wr = 1; end
            7: begin r = 0;       fv = 0; fc = 0; wr = 1; end
            9: begin r = x;       fv = 0; fc = 0; end
            10: begin
                if (w == 16) r = {48'd0, {8{d[7]}}, d[7:0]};
                else         r = {32'd0, {16{d[15]}}, d[15:0]};
                fv = 0; fc = 0; wr = 1; end
            11: begin r = {32'd0, d[15:0], d[31:16]}; fv = 0; fc = 0; wr = 1; end
            default: ;
        endcase
        setf = 1;
        fn = r[w-1]; fz = (r == 0);
        if (wr) m_res = (d & ~m[31:0]) | r[31:0];
        m_wr = wr;
        if (setf) m_flg = {fx, fn, fz, fv, fc};
    endtask

    task automatic compare(string tag);
        checks++;
        if (out_valid !== m_vld || wr_en !== m_wr || result !== m_res || flags !== m_flg) begin
            errors++;
            $display("FAIL %s: got vld=%0b wr=%0b res=%h flg=%b, expected vld=%0b wr=%0b res=%h flg=%b",
                     tag, out_valid, wr_en, result, flags, m_vld, m_wr, m_res, m_flg);
        end
    endtask

    // Drive one operation at a falling edge and check it one cycle later.
    task automatic issue(int o, int sz, bit a, logic [31:0] s, logic [31:0] d);
        string t;
        in_valid = 1; op = 4'(o); size = 2'(sz); dst_is_addr = a; src = s; dst = d;
        t = tag_of(o, a);
        model(o, sz, a, s, d);
        @(negedge clk);
        compare(t);
    endtask

    task automatic idle();
        in_valid = 0; src = 32'hDEAD_BEEF; dst = 32'h1234_5678; op = 4'd0;
        m_vld = 0; m_wr = 0;
        @(negedge clk);
        compare("R2");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        compare("R1");                         // R1 reset state
        issue(0, 0, 0, 32'h0000_0001, 32'hAABB_CC7F); // R3 byte add overflow, upper kept R6
        issue(0, 0, 0, 32'h0000_0001, 32'h1111_22FF); // R3 byte carry
        issue(2, 0, 0, 32'h0000_00F0, 32'h5555_550F); // R5 AND keeps X
        idle();                                       // R2
        issue(1, 1, 0, 32'h0000_0001, 32'hFFFF_0000); // R3 word borrow
        issue(1, 2, 0, 32'h0000_0001, 32'h8000_0000); // R3 long overflow
        issue(6, 0, 0, 32'h0, 32'h1234_5680);         // R4 negate most negative byte
        issue(6, 2, 0, 32'h0, 32'h0000_0000);         // R4 negate zero
        issue(5, 1, 0, 32'h0, 32'hCAFE_00FF);         // R4/R5 complement word
        issue(8, 2, 0, 32'h0000_0005, 32'h0000_0003); // R7 compare
        issue(9, 0, 0, 32'h0, 32'h1234_5600);         // R8 test zero byte
        issue(10, 1, 0, 32'h0, 32'hABCD_1280);        // R9 byte to word
        issue(10, 2, 0, 32'h0, 32'h0000_8001);        // R9 word to long
        issue(11, 2, 0, 32'h0, 32'h1234_ABCD);        // R10 swap
        issue(7, 1, 0, 32'h0, 32'hFFFF_FFFF);         // R11 clear word
        issue(12, 1, 1, 32'h0000_8000, 32'h0);        // R12 address move sext
        issue(0, 1, 1, 32'h0000_FFFF, 32'h0000_1000); // R12 address add sext
        issue(8, 1, 1, 32'h0000_FFFF, 32'hFFFF_FFFF); // R12 address compare
        issue(7, 2, 1, 32'h0, 32'h7777_7777);         // R13 clear refused
        issue(4, 2, 1, 32'hFFFF_FFFF, 32'h1);         // R13 xor refused
        for (int i = 0; i < 400; i++) begin
            int o, sz;
            bit a;
            o  = $urandom_range(12, 0);
            sz = $urandom_range(2, 0);
            a  = ($urandom_range(3, 0) == 0);
            if (a && sz == 0) sz = 1;
            if (($urandom_range(7, 0)) == 0) idle();
            issue(o, sz, a, $urandom, $urandom);
        end
        idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule